// File: doc/BRIEF.md
# Capture, Compare and Pulse-Width Unit

This block is a timer peripheral with one 16-bit working register, split into a low byte and a high byte, and a 4-bit mode field. It does not contain any timer. It watches two timers that live elsewhere: a 16-bit free-running count, and an 8-bit count with a 2-bit prescale phase. In capture modes it copies the 16-bit count into the working register when the chosen edges arrive on a pin input. In compare modes it tests the working register against the 16-bit count. A match can set or clear the pin output, raise only the interrupt flag, or pulse a pair of strobes that clear the 16-bit timer and start a conversion. In pulse-width modes it uses the 10-bit combined count to drive a 10-bit duty cycle onto the pin output.

Software reaches the block through a byte-wide port with four addresses. The low byte of the working register also holds the upper eight bits of the pulse-width duty. The two lowest duty bits sit in the control byte, next to the mode field. The interrupt flag stays set until software clears it.

Top module: `ccp_unit`

## Requirements
- R1: After reset, all four readable bytes are zero and pinOut, irqFlag, timerClr and convStart are all low.
- R2: rdData follows addr with no register in the path. Address 0 is the low byte and address 1 is the high byte of the working register. Address 2 is the control byte: bits 3:0 are the mode, bits 5:4 are the duty LSBs, and bits 7:6 always read 0. Address 3 returns the flag in bit 0. A write takes effect at the clock edge where wrEn is high.
- R3: irqFlag is set by a capture or a compare match and then stays set. Writing address 3 with bit 0 at 0 clears it. Writing 1 has no effect. If a set and a clear fall in the same cycle, the set wins.
- R4: pinIn passes through two synchronizing flops before edge detection. A pin change that is presented before clock edge k is acted on at edge k+2, and the capture takes the 16-bit count seen at that edge.
- R5: Mode 4'b0100 captures on every falling edge of the pin and mode 4'b0101 captures on every rising edge. A capture has priority over a software write to the same byte.
- R6: Mode 4'b0110 captures on every 4th rising edge and mode 4'b0111 on every 16th. Any write that changes the mode restarts the edge count.
- R7: Mode 4'b1000 drives pinOut low when the mode is entered and high on a match. Mode 4'b1001 drives pinOut high when the mode is entered and low on a match. A match is the working register equal to the 16-bit count.
- R8: Mode 4'b1010 sets the flag on a match and leaves pinOut unchanged.
- R9: In mode 4'b1011, every cycle with a match gives a one-cycle pulse on both timerClr and convStart in the following cycle, and also sets the flag.
- R10: Modes 4'b11xx produce pulse-width output. The duty is the low byte followed by control bits 5:4, and the count is the 8-bit timer followed by its 2-bit phase. pinOut is high one cycle after a count below the active duty. At count 0 pinOut is forced high if the pending duty is nonzero.
- R11: A duty write takes effect only at the next count of 0. Until then the active duty keeps its old value.
- R12: Mode 4'b0000, the reserved modes 4'b0001 to 4'b0011, and the capture modes drive pinOut low. The off and reserved modes also clear the active duty and the edge count, but leave the readable bytes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Byte write strobe |
| addr | input | 2 | Byte address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for addr |
| slowTimer | input | 16 | 16-bit time base for capture and compare |
| fastTimer | input | 8 | 8-bit pulse-width time base |
| fastPre | input | 2 | Prescale phase of the 8-bit time base |
| pinIn | input | 1 | Asynchronous capture pin |
| pinOut | output | 1 | Compare or pulse-width pin, registered |
| irqFlag | output | 1 | Sticky interrupt flag |
| timerClr | output | 1 | One-cycle request to clear the 16-bit timer |
| convStart | output | 1 | One-cycle request to start a conversion |

## Verification
Each result has a fixed latency, and the bench is built around it. Register writes, the flag, and the compare-driven pin and strobes all change at the edge that samples the cause, and the bench sees them at the next falling edge. A capture is due two edges after the edge where the pin change is first sampled. Pulse-width levels lag their count by exactly one edge. The reference model updates on each rising edge using the same sampled inputs, and every output is compared against it at the following falling edge, so each comparison falls exactly where the result is due. Explicit checks count captured values, strobe pulses and high cycles in a period over windows that are aligned to these latencies.

// File: rtl/ccp_pkg.sv
package ccp_pkg;
  localparam logic [3:0] MODE_OFF      = 4'b0000;
  localparam logic [3:0] MODE_CAP_FALL = 4'b0100;
  localparam logic [3:0] MODE_CAP_RISE = 4'b0101;
  localparam logic [3:0] MODE_CAP_4    = 4'b0110;
  localparam logic [3:0] MODE_CAP_16   = 4'b0111;
  localparam logic [3:0] MODE_CMP_SET  = 4'b1000;
  localparam logic [3:0] MODE_CMP_CLR  = 4'b1001;
  localparam logic [3:0] MODE_CMP_SOFT = 4'b1010;
  localparam logic [3:0] MODE_CMP_EVT  = 4'b1011;

  localparam logic [1:0] ADDR_LOW  = 2'd0;
  localparam logic [1:0] ADDR_HIGH = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;
  localparam logic [1:0] ADDR_FLAG = 2'd3;

  typedef struct packed {
    logic capture;
    logic dutyLoad;
    logic dutyClear;
  } ccpStrobe_t;

  function automatic logic isCapture(input logic [3:0] m);
    return m[3:2] == 2'b01;
  endfunction

  function automatic logic isCompare(input logic [3:0] m);
    return m[3:2] == 2'b10;
  endfunction

  function automatic logic isPwm(input logic [3:0] m);
    return m[3:2] == 2'b11;
  endfunction
endpackage

// File: rtl/ccp_datapath.sv
module ccp_datapath
  import ccp_pkg::*;
#(
  parameter int TIMER_W = 16,
  parameter int BYTE_W  = 8,
  parameter int PRE_W   = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [1:0]         addr,
  input  logic [BYTE_W-1:0]  wrData,
  output logic [BYTE_W-1:0]  rdData,
  input  logic [TIMER_W-1:0] slowTimer,
  input  logic [BYTE_W+PRE_W-1:0] pwmCount,
  input  ccpStrobe_t         strobe,
  input  logic               irqFlag,
  output logic [3:0]         mode,
  output logic [3:0]         newMode,
  output logic               modeChange,
  output logic               match,
  output logic               pwmLevel,
  output logic               periodStart
);
  localparam int NUM_BYTES = TIMER_W / BYTE_W;
  localparam int CNT_W     = BYTE_W + PRE_W;
  localparam int CTRL_W    = 4 + PRE_W;

  logic [TIMER_W-1:0] ccpReg;
  logic [CTRL_W-1:0]  ctrlBits;
  logic [CNT_W-1:0]   dutyBuf;
  logic [CNT_W-1:0]   activeDuty;

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        ccpReg[b*BYTE_W +: BYTE_W] <= '0;
      else if (strobe.capture)
        ccpReg[b*BYTE_W +: BYTE_W] <= slowTimer[b*BYTE_W +: BYTE_W];
      else if (wrEn && addr == 2'(b))
        ccpReg[b*BYTE_W +: BYTE_W] <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      ctrlBits <= '0;
    else if (wrEn && addr == ADDR_CTRL)
      ctrlBits <= wrData[CTRL_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      activeDuty <= '0;
    else if (strobe.dutyClear)
      activeDuty <= '0;
    else if (strobe.dutyLoad)
      activeDuty <= dutyBuf;
  end

  assign mode        = ctrlBits[3:0];
  assign newMode     = wrData[3:0];
  assign modeChange  = wrEn && addr == ADDR_CTRL && wrData[3:0] != ctrlBits[3:0];
  assign dutyBuf     = {ccpReg[BYTE_W-1:0], ctrlBits[CTRL_W-1:4]};
  assign match       = isCompare(mode) && ccpReg == slowTimer;
  assign periodStart = pwmCount == '0;
  assign pwmLevel    = periodStart ? (dutyBuf != '0) : (pwmCount < activeDuty);

  always_comb begin
    case (addr)
      ADDR_LOW:  rdData = ccpReg[BYTE_W-1:0];
      ADDR_HIGH: rdData = ccpReg[2*BYTE_W-1:BYTE_W];
      ADDR_CTRL: rdData = BYTE_W'(ctrlBits);
      default:   rdData = BYTE_W'(irqFlag);
    endcase
  end

  // R11: the active duty only moves at a period start or when leaving PWM
  a_r11_duty_buffered: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(activeDuty) |-> $past(periodStart || !isPwm(mode)));

  // R5: a capture leaves the 16-bit count in the working register
  a_r5_capture_value: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> ccpReg == $past(slowTimer));
endmodule

// File: rtl/ccp_ctrl.sv
module ccp_ctrl
  import ccp_pkg::*;
#(
  parameter int EDGE_CNT_W = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pinIn,
  input  logic       wrEn,
  input  logic [1:0] addr,
  input  logic       wrBit0,
  input  logic [3:0] mode,
  input  logic [3:0] newMode,
  input  logic       modeChange,
  input  logic       match,
  input  logic       pwmLevel,
  input  logic       periodStart,
  output ccpStrobe_t strobe,
  output logic       pinOut,
  output logic       irqFlag,
  output logic       timerClr,
  output logic       convStart
);
  localparam logic [EDGE_CNT_W-1:0] LIMIT_4  = EDGE_CNT_W'(3);
  localparam logic [EDGE_CNT_W-1:0] LIMIT_16 = EDGE_CNT_W'(15);

  logic syncA, syncB, syncC;
  logic riseSeen, fallSeen;
  logic [EDGE_CNT_W-1:0] edgeCnt, edgeLimit;
  logic prescaled, capHit, pinNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
      syncC <= 1'b0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
      syncC <= syncB;
    end
  end

  assign riseSeen  = syncB && !syncC;
  assign fallSeen  = !syncB && syncC;
  assign prescaled = mode == MODE_CAP_4 || mode == MODE_CAP_16;
  assign edgeLimit = (mode == MODE_CAP_4) ? LIMIT_4 : LIMIT_16;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      edgeCnt <= '0;
    else if (modeChange || !prescaled)
      edgeCnt <= '0;
    else if (riseSeen)
      edgeCnt <= (edgeCnt == edgeLimit) ? '0 : edgeCnt + 1'b1;
  end

  always_comb begin
    case (mode)
      MODE_CAP_FALL: capHit = fallSeen;
      MODE_CAP_RISE: capHit = riseSeen;
      MODE_CAP_4, MODE_CAP_16: capHit = riseSeen && edgeCnt == edgeLimit;
      default:       capHit = 1'b0;
    endcase
  end

  assign strobe.capture   = capHit;
  assign strobe.dutyLoad  = isPwm(mode) && periodStart;
  assign strobe.dutyClear = !isPwm(mode);

  always_comb begin
    pinNext = 1'b0;
    if (modeChange) begin
      case (newMode)
        MODE_CMP_CLR:                pinNext = 1'b1;
        MODE_CMP_SOFT, MODE_CMP_EVT: pinNext = pinOut;
        default:                     pinNext = 1'b0;
      endcase
    end else if (isPwm(mode)) begin
      pinNext = pwmLevel;
    end else if (isCompare(mode)) begin
      pinNext = pinOut;
      if (match && mode == MODE_CMP_SET) pinNext = 1'b1;
      if (match && mode == MODE_CMP_CLR) pinNext = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinOut    <= 1'b0;
      irqFlag   <= 1'b0;
      timerClr  <= 1'b0;
      convStart <= 1'b0;
    end else begin
      pinOut    <= pinNext;
      timerClr  <= match && mode == MODE_CMP_EVT;
      convStart <= match && mode == MODE_CMP_EVT;
      if (capHit || match)
        irqFlag <= 1'b1;
      else if (wrEn && addr == ADDR_FLAG && !wrBit0)
        irqFlag <= 1'b0;
    end
  end

  // R3: the flag falls only after a clearing write
  a_r3_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqFlag) |-> $past(wrEn && addr == ADDR_FLAG && !wrBit0));

  // R9: the conversion strobe follows a compare match
  a_r9_strobe_after_match: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> $past(match));

  // R7: in set mode the pin never falls without a mode change
  a_r7_set_no_fall: assert property (@(posedge clk) disable iff (!rstN)
    $past(mode == MODE_CMP_SET && !modeChange) |-> !$fell(pinOut));

  // R8: the soft compare mode leaves the pin alone
  a_r8_soft_pin_stable: assert property (@(posedge clk) disable iff (!rstN)
    $past(mode == MODE_CMP_SOFT && !modeChange) |-> $stable(pinOut));

  // R12: off, reserved and capture modes keep the pin low
  a_r12_idle_pin_low: assert property (@(posedge clk) disable iff (!rstN)
    $past(!isPwm(mode) && !isCompare(mode) && !modeChange) |-> !pinOut);

  // R6: the divide-by-4 count stays inside its range
  a_r6_edge_range: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_CAP_4 && $stable(mode)) |-> edgeCnt <= LIMIT_4);
endmodule

// File: rtl/ccp_unit.sv
module ccp_unit
  import ccp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [1:0]  addr,
  input  logic [7:0]  wrData,
  output logic [7:0]  rdData,
  input  logic [15:0] slowTimer,
  input  logic [7:0]  fastTimer,
  input  logic [1:0]  fastPre,
  input  logic        pinIn,
  output logic        pinOut,
  output logic        irqFlag,
  output logic        timerClr,
  output logic        convStart
);
  ccpStrobe_t strobe;
  logic [3:0] mode, newMode;
  logic       modeChange, match, pwmLevel, periodStart;

  ccp_datapath #(.TIMER_W(16), .BYTE_W(8), .PRE_W(2)) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .addr       (addr),
    .wrData     (wrData),
    .rdData     (rdData),
    .slowTimer  (slowTimer),
    .pwmCount   ({fastTimer, fastPre}),
    .strobe     (strobe),
    .irqFlag    (irqFlag),
    .mode       (mode),
    .newMode    (newMode),
    .modeChange (modeChange),
    .match      (match),
    .pwmLevel   (pwmLevel),
    .periodStart(periodStart)
  );

  ccp_ctrl #(.EDGE_CNT_W(4)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .pinIn      (pinIn),
    .wrEn       (wrEn),
    .addr       (addr),
    .wrBit0     (wrData[0]),
    .mode       (mode),
    .newMode    (newMode),
    .modeChange (modeChange),
    .match      (match),
    .pwmLevel   (pwmLevel),
    .periodStart(periodStart),
    .strobe     (strobe),
    .pinOut     (pinOut),
    .irqFlag    (irqFlag),
    .timerClr   (timerClr),
    .convStart  (convStart)
  );
endmodule

// File: tb/test_ccp_unit.sv
module test_ccp_unit;
  localparam int PER = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;
  logic [15:0] slowTimer = 16'h1000;
  logic [9:0] pwmCnt = 10'd0;
  logic pwmRun = 1'b0;
  logic pinIn = 1'b0;
  logic pinOut, irqFlag, timerClr, convStart;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  // reference model state
  logic [15:0] mReg;
  logic [5:0]  mCtrl;
  logic mFlag, mPin, mClr, mConv, ms1, ms2, ms3;
  int mPre;
  int mActive;

  always #5 clk = ~clk;

  ccp_unit i_ccp_unit (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .slowTimer(slowTimer), .fastTimer(pwmCnt[9:2]),
    .fastPre(pwmCnt[1:0]), .pinIn(pinIn), .pinOut(pinOut),
    .irqFlag(irqFlag), .timerClr(timerClr), .convStart(convStart)
  );

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mReg = 16'd0; mCtrl = 6'd0; mFlag = 1'b0; mPin = 1'b0;
      mClr = 1'b0; mConv = 1'b0; ms1 = 1'b0; ms2 = 1'b0; ms3 = 1'b0;
      mPre = 0; mActive = 0;
    end else begin : model
      automatic logic [3:0] md = mCtrl[3:0];
      automatic bit rise = ms2 && !ms3;
      automatic bit fall = !ms2 && ms3;
      automatic bit chg = wrEn && addr == 2'd2 && wrData[3:0] != md;
      automatic int lim = (md == 4'b0110) ? 3 : 15;
      automatic bit cap = (md == 4'b0100 && fall) || (md == 4'b0101 && rise) ||
                          ((md == 4'b0110 || md == 4'b0111) && rise && mPre == lim);
      automatic bit hit = md[3:2] == 2'b10 && mReg == slowTimer;
      automatic int cnt = int'(pwmCnt);
      automatic int dbuf = int'(mReg[7:0]) * 4 + int'(mCtrl[5:4]);
      automatic bit pn;
      if (chg) pn = (wrData[3:0] == 4'b1001) ? 1'b1 :
                    (wrData[3:0] == 4'b1010 || wrData[3:0] == 4'b1011) ? mPin : 1'b0;
      else if (md[3:2] == 2'b11) pn = (cnt == 0) ? (dbuf != 0) : (cnt < mActive);
      else if (md == 4'b1000) pn = hit ? 1'b1 : mPin;
      else if (md == 4'b1001) pn = hit ? 1'b0 : mPin;
      else if (md[3:2] == 2'b10) pn = mPin;
      else pn = 1'b0;
      if (md[3:2] != 2'b11) mActive = 0;
      else if (cnt == 0) mActive = dbuf;
      if (chg || !(md == 4'b0110 || md == 4'b0111)) mPre = 0;
      else if (rise) mPre = (mPre == lim) ? 0 : mPre + 1;
      if (cap || hit) mFlag = 1'b1;
      else if (wrEn && addr == 2'd3 && !wrData[0]) mFlag = 1'b0;
      if (cap) mReg = slowTimer;
      else if (wrEn && addr == 2'd0) mReg[7:0] = wrData;
      else if (wrEn && addr == 2'd1) mReg[15:8] = wrData;
      if (wrEn && addr == 2'd2) mCtrl = wrData[5:0];
      mClr = md == 4'b1011 && hit;
      mConv = md == 4'b1011 && hit;
      mPin = pn;
      ms3 = ms2; ms2 = ms1; ms1 = pinIn;
    end
  end

  function automatic string modeTag(input logic [3:0] md);
    if (md == 4'b0100 || md == 4'b0101) return "R5";
    if (md == 4'b0110 || md == 4'b0111) return "R6";
    if (md == 4'b1000 || md == 4'b1001) return "R7";
    if (md == 4'b1010) return "R8";
    if (md == 4'b1011) return "R9";
    if (md[3:2] == 2'b11) return "R10";
    return "R12";
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    logic [7:0] er;
    case (addr)
      2'd0: er = mReg[7:0];
      2'd1: er = mReg[15:8];
      2'd2: er = {2'b00, mCtrl};
      default: er = {7'd0, mFlag};
    endcase
    check(pinOut === mPin, modeTag(mCtrl[3:0]), int'(pinOut), int'(mPin));
    check(irqFlag === mFlag, "R3", int'(irqFlag), int'(mFlag));
    check(timerClr === mClr && convStart === mConv, "R9",
          int'({timerClr, convStart}), int'({mClr, mConv}));
    check(rdData === er, "R2", int'(rdData), int'(er));
  endtask

  task automatic step();
    @(negedge clk);
    compareAll();
    slowTimer = slowTimer + 16'd1;
    if (pwmRun) pwmCnt = (pwmCnt == 10'(PER - 1)) ? 10'd0 : pwmCnt + 10'd1;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [7:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    step();
    wrEn = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1 d = rdData;
  endtask

  task automatic pulsePin(input int n);
    for (int i = 0; i < n; i++) begin
      pinIn = 1'b1; steps(3);
      pinIn = 1'b0; steps(3);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin : stimulus
    logic [7:0] rv;
    logic [15:0] tval;
    int cntA, cntB;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    for (int a = 0; a < 4; a++) begin
      readReg(2'(a), rv);
      check(rv == 8'd0, "R1", int'(rv), 0);
    end
    check(!pinOut && !irqFlag && !timerClr && !convStart, "R1",
          int'({pinOut, irqFlag, timerClr, convStart}), 0);

    // R2: register access and unused control bits
    writeReg(2'd0, 8'hA5);
    writeReg(2'd1, 8'h3C);
    writeReg(2'd2, 8'hF2);
    readReg(2'd2, rv);
    check(rv == 8'h32, "R2", int'(rv), 'h32);
    readReg(2'd1, rv);
    check(rv == 8'h3C, "R2", int'(rv), 'h3C);
    writeReg(2'd2, 8'h00);

    // R4 and R5: rising edge capture with two-flop latency
    writeReg(2'd2, 8'h05);
    steps(2);
    tval = slowTimer;
    pinIn = 1'b1;
    steps(3);
    readReg(2'd0, rv);
    check(rv == tval[7:0] + 8'd2, "R4", int'(rv), int'(tval[7:0] + 8'd2));
    readReg(2'd1, rv);
    check(rv == 8'(({8'd0, tval} + 24'd2) >> 8), "R4", int'(rv), int'((tval + 16'd2) >> 8));
    check(irqFlag, "R3", int'(irqFlag), 1);
    writeReg(2'd3, 8'h01);
    check(irqFlag, "R3", int'(irqFlag), 1);
    writeReg(2'd3, 8'h00);
    check(!irqFlag, "R3", int'(irqFlag), 0);
    pinIn = 1'b0; steps(4);
    check(!irqFlag, "R5", int'(irqFlag), 0);
    writeReg(2'd2, 8'h04);
    pulsePin(2);
    check(irqFlag, "R5", int'(irqFlag), 1);
    writeReg(2'd3, 8'h00);

    // R6: prescaled capture and restart on mode change
    writeReg(2'd2, 8'h06);
    pulsePin(3);
    check(!irqFlag, "R6", int'(irqFlag), 0);
    pulsePin(1);
    check(irqFlag, "R6", int'(irqFlag), 1);
    writeReg(2'd3, 8'h00);
    writeReg(2'd2, 8'h07);
    pulsePin(5);
    writeReg(2'd2, 8'h06);
    pulsePin(3);
    check(!irqFlag, "R6", int'(irqFlag), 0);
    pulsePin(1);
    check(irqFlag, "R6", int'(irqFlag), 1);
    writeReg(2'd3, 8'h00);
    writeReg(2'd2, 8'h07);
    pulsePin(16);
    check(irqFlag, "R6", int'(irqFlag), 1);
    writeReg(2'd2, 8'h00);
    writeReg(2'd3, 8'h00);

    // R7: set and clear on match
    tval = slowTimer + 16'd20;
    writeReg(2'd0, tval[7:0]);
    writeReg(2'd1, tval[15:8]);
    writeReg(2'd2, 8'h08);
    check(!pinOut, "R7", int'(pinOut), 0);
    steps(30);
    check(pinOut && irqFlag, "R7", int'({pinOut, irqFlag}), 3);
    writeReg(2'd3, 8'h00);
    tval = slowTimer + 16'd20;
    writeReg(2'd0, tval[7:0]);
    writeReg(2'd1, tval[15:8]);
    writeReg(2'd2, 8'h09);
    check(pinOut, "R7", int'(pinOut), 1);
    steps(30);
    check(!pinOut, "R7", int'(pinOut), 0);
    writeReg(2'd3, 8'h00);

    // R8: flag only, pin untouched
    writeReg(2'd2, 8'h08);
    tval = slowTimer + 16'd20;
    writeReg(2'd0, tval[7:0]);
    writeReg(2'd1, tval[15:8]);
    writeReg(2'd2, 8'h0A);
    steps(30);
    check(!pinOut && irqFlag, "R8", int'({pinOut, irqFlag}), 1);
    writeReg(2'd3, 8'h00);

    // R9: special event strobes
    tval = slowTimer + 16'd20;
    writeReg(2'd0, tval[7:0]);
    writeReg(2'd1, tval[15:8]);
    writeReg(2'd2, 8'h0B);
    cntA = 0; cntB = 0;
    for (int i = 0; i < 30; i++) begin
      step();
      if (timerClr) cntA++;
      if (convStart) cntB++;
    end
    check(cntA == 1 && cntB == 1, "R9", cntA * 16 + cntB, 'h11);
    writeReg(2'd3, 8'h00);
    writeReg(2'd2, 8'h00);

    // R10 and R11: PWM with double-buffered duty
    pwmRun = 1'b1;
    writeReg(2'd0, 8'd5);
    writeReg(2'd2, 8'h2C);
    steps(2 * PER);
    while (pwmCnt != 10'd10) step();
    writeReg(2'd0, 8'd7);
    cntA = 0;
    for (int i = 0; i < PER; i++) begin
      step();
      if (pinOut) cntA++;
    end
    check(cntA == 22, "R11", cntA, 22);
    cntA = 0;
    for (int i = 0; i < PER; i++) begin
      step();
      if (pinOut) cntA++;
    end
    check(cntA == 30, "R10", cntA, 30);
    writeReg(2'd0, 8'd0);
    writeReg(2'd2, 8'h1C);
    steps(2 * PER);
    cntA = 0;
    for (int i = 0; i < PER; i++) begin
      step();
      if (pinOut) cntA++;
    end
    check(cntA == 1, "R10", cntA, 1);
    writeReg(2'd2, 8'h0C);
    steps(2 * PER);
    check(!pinOut, "R10", int'(pinOut), 0);
    writeReg(2'd0, 8'd200);
    steps(2 * PER);
    check(pinOut, "R10", int'(pinOut), 1);

    // R12: off mode drives pin low and keeps registers
    writeReg(2'd2, 8'h00);
    check(!pinOut, "R12", int'(pinOut), 0);
    readReg(2'd0, rv);
    check(rv == 8'd200, "R12", int'(rv), 200);
    writeReg(2'd2, 8'h02);
    steps(5);
    check(!pinOut, "R12", int'(pinOut), 0);
    pwmRun = 1'b0;
    steps(3);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule